// File: doc/BRIEF.md
# Bus Width Cycle Splitter

This block sits between a 32-bit processor bus and targets whose data path may be 32, 16 or 8 bits wide. A processor cycle arrives with a word address, four byte enables, a direction and a 32-bit write word. When the splitter accepts the request, it samples two target selects to learn the port width. A 32-bit memory select means one full-width cycle. A 16-bit select without the 32-bit one means a 16-bit port. With neither select, the target is treated as an 8-bit port.

The splitter then runs the needed number of target sub-cycles, at most one per byte lane. For each sub-cycle it produces the low address bits and places the data on the lanes that the narrow target uses. On 16-bit sub-cycles it drives the byte-high enable. Read bytes are gathered back into their original lanes. A single-cycle processor ready marks the end of the access. Each sub-cycle lasts until the target raises its ready input, so slow targets stretch the sequence.

Top module: `bus_width_splitter`

## Requirements
- R1: After reset, cpu_ready, tgt_cyc and tgt_bhe are low and cpu_rdata reads zero.
- R2: With tgt_sel32 high at acceptance, exactly one sub-cycle runs. Its address bits [1:0] are 00, tgt_be equals the processor byte enables, and bytes keep their own lanes.
- R3: On a 16-bit port, one sub-cycle runs for each half (lanes 1:0 and lanes 3:2) that has an enabled byte. Address bit 1 selects the half. Address bit 0 is 1 only when the half's low byte is disabled. Data for lanes 3:2 travels on bits 15:0.
- R4: tgt_bhe is high exactly in 16-bit sub-cycles whose half has its upper byte enabled. It is never high on 8-bit or 32-bit sub-cycles. When an odd byte is written alone, it travels on bits 15:8.
- R5: On an 8-bit port (neither select), one sub-cycle runs per enabled byte. Its address bits [1:0] equal the lane number, and its data travels on bits 7:0.
- R6: Sub-cycles run in ascending address order.
- R7: On reads, each sub-cycle's bytes are placed into their original lanes of cpu_rdata. Lanes whose enable is low read as zero. Target data lanes that the port width does not use are ignored.
- R8: Each sub-cycle holds its address, data and enables until tgt_ready is sampled high. For N sub-cycles with W wait cycles each, cpu_ready is seen 1 + N*(W+1) cycles after the request is first sampled.
- R9: cpu_ready is a one-cycle pulse in the cycle after the last sub-cycle completes. A request still held during that pulse does not start a new access.
- R10: When both selects are high at acceptance, the 32-bit select wins.
- R11: A request with no byte enabled completes with cpu_ready on the next cycle. It runs no target sub-cycle and reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor access request, accepted when idle |
| cpu_addr | input | ADDR_W | Processor address; bits [1:0] ignored |
| cpu_be | input | 4 | Processor byte enables, bit n for lane n |
| cpu_write | input | 1 | 1 for write, 0 for read |
| cpu_wdata | input | 32 | Processor write word |
| cpu_rdata | output | 32 | Assembled read word |
| cpu_ready | output | 1 | One-cycle completion pulse |
| tgt_sel32 | input | 1 | Target is a 32-bit memory |
| tgt_sel16 | input | 1 | Target is a 16-bit device |
| tgt_cyc | output | 1 | Sub-cycle active |
| tgt_addr | output | ADDR_W | Sub-cycle address with generated low bits |
| tgt_write | output | 1 | Sub-cycle direction |
| tgt_be | output | 4 | Lane enables for 32-bit sub-cycles, zero otherwise |
| tgt_bhe | output | 1 | Upper byte enable for 16-bit sub-cycles |
| tgt_wdata | output | 32 | Steered write data |
| tgt_rdata | input | 32 | Target read data |
| tgt_ready | input | 1 | Target completes the current sub-cycle |

## Verification
Two functions meet in one clock edge. The target ready of the final sub-cycle merges that sub-cycle's read bytes into the assembled word, and the same edge ends the sequence, so cpu_ready appears next. The bench provokes this on every read by returning lane-specific bytes, with garbage on unused lanes. On the cpu_ready cycle it checks that the last-served lane already holds its byte. A second case holds the request high through the ready pulse. The bench then judges that no new sub-cycle starts in the following cycle.

// File: rtl/bwsplit_pkg.sv
package bwsplit_pkg;

    localparam int LANES     = 4;
    localparam int BYTE_W    = 8;
    localparam int DATA_W    = LANES * BYTE_W;
    localparam int HALF_W    = DATA_W / 2;
    localparam int LANE_BITS = $clog2(LANES);

    typedef enum logic [1:0] {
        PORT_W8  = 2'd0,
        PORT_W16 = 2'd1,
        PORT_W32 = 2'd2
    } port_width_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } split_state_e;

    typedef struct packed {
        logic [LANES-1:0]     mask;
        logic [LANE_BITS-1:0] low;
        logic                 bhe;
    } sub_plan_t;

    function automatic port_width_e pick_width(input logic sel32, input logic sel16);
        if (sel32)
            return PORT_W32;
        else if (sel16)
            return PORT_W16;
        else
            return PORT_W8;
    endfunction

endpackage

// File: rtl/bw_subplan.sv
module bw_subplan
    import bwsplit_pkg::*;
(
    input  port_width_e      width,
    input  logic [LANES-1:0] pending,
    output sub_plan_t        plan
);

    always_comb begin
        plan = '0;
        case (width)
            PORT_W32: begin
                plan.mask = pending;
            end
            PORT_W16: begin
                if (pending[1:0] != 2'b00) begin
                    plan.mask = {2'b00, pending[1:0]};
                    plan.low  = {1'b0, ~pending[0]};
                    plan.bhe  = pending[1];
                end else begin
                    plan.mask = {pending[3:2], 2'b00};
                    plan.low  = {1'b1, ~pending[2]};
                    plan.bhe  = pending[3];
                end
            end
            default: begin
                for (int i = LANES - 1; i >= 0; i--) begin
                    if (pending[i]) begin
                        plan.mask = LANES'(1) << i;
                        plan.low  = LANE_BITS'(i);
                    end
                end
            end
        endcase
    end

endmodule

// File: rtl/bw_lane_steer.sv
module bw_lane_steer
    import bwsplit_pkg::*;
(
    input  port_width_e       width,
    input  sub_plan_t         plan,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] rdata_in,
    input  logic [DATA_W-1:0] rbuf,
    output logic [DATA_W-1:0] wdata_out,
    output logic [DATA_W-1:0] merged
);

    always_comb begin
        case (width)
            PORT_W32: wdata_out = wdata;
            PORT_W16: begin
                if (plan.mask[3:2] != 2'b00)
                    wdata_out = {{HALF_W{1'b0}}, wdata[DATA_W-1:HALF_W]};
                else
                    wdata_out = {{HALF_W{1'b0}}, wdata[HALF_W-1:0]};
            end
            default:
                wdata_out = {{(DATA_W-BYTE_W){1'b0}}, wdata[{plan.low, 3'b000} +: BYTE_W]};
        endcase
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [BYTE_W-1:0] src;
        always_comb begin
            case (width)
                PORT_W32: src = rdata_in[BYTE_W*g +: BYTE_W];
                PORT_W16: src = rdata_in[BYTE_W*(g%2) +: BYTE_W];
                default:  src = rdata_in[BYTE_W-1:0];
            endcase
        end
        assign merged[BYTE_W*g +: BYTE_W] = plan.mask[g] ? src : rbuf[BYTE_W*g +: BYTE_W];
    end

endmodule

// File: rtl/bus_width_splitter.sv
module bus_width_splitter
    import bwsplit_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [LANES-1:0]  cpu_be,
    input  logic              cpu_write,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    input  logic              tgt_sel32,
    input  logic              tgt_sel16,
    output logic              tgt_cyc,
    output logic [ADDR_W-1:0] tgt_addr,
    output logic              tgt_write,
    output logic [LANES-1:0]  tgt_be,
    output logic              tgt_bhe,
    output logic [DATA_W-1:0] tgt_wdata,
    input  logic [DATA_W-1:0] tgt_rdata,
    input  logic              tgt_ready
);

    localparam int CNT_W = $clog2(LANES + 1) + 1;

    split_state_e             state_q;
    port_width_e              width_q;
    logic [LANES-1:0]         pend_q;
    logic [ADDR_W-1:0]        addr_q;
    logic                     wr_q;
    logic [DATA_W-1:0]        wdata_q;
    logic [DATA_W-1:0]        rbuf_q;

    sub_plan_t                plan;
    logic [DATA_W-1:0]        merged;
    logic [DATA_W-1:0]        steer_wdata;
    logic                     retire;
    logic [LANES-1:0]         remain;

    bw_subplan u_plan (
        .width   (width_q),
        .pending (pend_q),
        .plan    (plan)
    );

    bw_lane_steer u_steer (
        .width     (width_q),
        .plan      (plan),
        .wdata     (wdata_q),
        .rdata_in  (tgt_rdata),
        .rbuf      (rbuf_q),
        .wdata_out (steer_wdata),
        .merged    (merged)
    );

    assign retire = (state_q == ST_RUN) && tgt_ready;
    assign remain = pend_q & ~plan.mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            width_q <= PORT_W8;
            pend_q  <= '0;
            addr_q  <= '0;
            wr_q    <= 1'b0;
            wdata_q <= '0;
            rbuf_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (cpu_req) begin
                        width_q <= pick_width(tgt_sel32, tgt_sel16);
                        pend_q  <= cpu_be;
                        addr_q  <= cpu_addr;
                        wr_q    <= cpu_write;
                        wdata_q <= cpu_wdata;
                        rbuf_q  <= '0;
                        state_q <= (cpu_be == '0) ? ST_DONE : ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (tgt_ready) begin
                        if (!wr_q)
                            rbuf_q <= merged;
                        pend_q <= remain;
                        if (remain == '0)
                            state_q <= ST_DONE;
                    end
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    assign cpu_ready = (state_q == ST_DONE);
    assign cpu_rdata = rbuf_q;
    assign tgt_cyc   = (state_q == ST_RUN);
    assign tgt_addr  = {addr_q[ADDR_W-1:LANE_BITS], plan.low};
    assign tgt_write = tgt_cyc && wr_q;
    assign tgt_be    = (tgt_cyc && width_q == PORT_W32) ? plan.mask : '0;
    assign tgt_bhe   = tgt_cyc && plan.bhe;
    assign tgt_wdata = steer_wdata;

    // checker state: order and count of retired sub-cycles
    logic                 seen_q;
    logic [LANE_BITS-1:0] prev_low_q;
    logic [CNT_W-1:0]     sub_cnt_q;

    always_ff @(posedge clk) begin
        if (rst || state_q == ST_IDLE) begin
            seen_q     <= 1'b0;
            prev_low_q <= '0;
            sub_cnt_q  <= '0;
        end else if (retire) begin
            seen_q     <= 1'b1;
            prev_low_q <= plan.low;
            sub_cnt_q  <= sub_cnt_q + 1'b1;
        end
    end

    // R4
    bhe_width_chk: assert property (@(posedge clk) disable iff (rst)
        tgt_bhe |-> (tgt_cyc && width_q == PORT_W16));

    // R9
    ready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_ready |=> !cpu_ready);

    // R8
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (tgt_cyc && !tgt_ready) |=> (tgt_cyc && $stable(tgt_addr) && $stable(tgt_wdata) && $stable(tgt_bhe)));

    // R6
    ascend_order_chk: assert property (@(posedge clk) disable iff (rst)
        (tgt_cyc && seen_q) |-> (tgt_addr[LANE_BITS-1:0] > prev_low_q));

    // R5
    sub_count_chk: assert property (@(posedge clk) disable iff (rst)
        sub_cnt_q <= CNT_W'(LANES));

endmodule

// File: tb/bus_width_splitter_tb_top.sv
module bus_width_splitter_tb_top;
    import bwsplit_pkg::*;

    localparam int AW = 24;

    logic          clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst;
    logic          cpu_req;
    logic [AW-1:0] cpu_addr;
    logic [3:0]    cpu_be;
    logic          cpu_write;
    logic [31:0]   cpu_wdata;
    logic [31:0]   cpu_rdata;
    logic          cpu_ready;
    logic          tgt_sel32;
    logic          tgt_sel16;
    logic          tgt_cyc;
    logic [AW-1:0] tgt_addr;
    logic          tgt_write;
    logic [3:0]    tgt_be;
    logic          tgt_bhe;
    logic [31:0]   tgt_wdata;
    logic [31:0]   tgt_rdata;
    logic          tgt_ready;

    bus_width_splitter #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
        .cpu_be(cpu_be), .cpu_write(cpu_write), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready), .tgt_sel32(tgt_sel32),
        .tgt_sel16(tgt_sel16), .tgt_cyc(tgt_cyc), .tgt_addr(tgt_addr),
        .tgt_write(tgt_write), .tgt_be(tgt_be), .tgt_bhe(tgt_bhe),
        .tgt_wdata(tgt_wdata), .tgt_rdata(tgt_rdata), .tgt_ready(tgt_ready)
    );

    int n_chk = 0;
    int n_bad = 0;
    int waitn = 0;
    int total = 0;
    int wcnt  = 0;
    logic [7:0] shadow [4];
    logic [1:0] log_low [64];
    logic       log_bhe [64];

    function automatic logic [7:0] fb(input logic [AW-1:0] a);
        return 8'(a[7:0] * 8'd5 + 8'h31);
    endfunction

    // target model: sampled and driven on the falling edge
    always @(negedge clk) begin
        logic [AW-1:0] wb;
        if (rst) begin
            tgt_ready = 1'b0;
            tgt_rdata = '0;
            wcnt = 0;
            for (int k = 0; k < 4; k++) shadow[k] = 8'hEE;
        end else if (tgt_cyc) begin
            if (wcnt < waitn) begin
                wcnt++;
                tgt_ready = 1'b0;
                tgt_rdata = 32'hBAD0BAD0;
            end else begin
                wcnt = 0;
                tgt_ready = 1'b1;
                log_low[total[5:0]] = tgt_addr[1:0];
                log_bhe[total[5:0]] = tgt_bhe;
                total++;
                wb = {tgt_addr[AW-1:2], 2'b00};
                if (tgt_sel32) begin
                    tgt_rdata = {fb(wb + 3), fb(wb + 2), fb(wb + 1), fb(wb)};
                    if (tgt_write)
                        for (int k = 0; k < 4; k++)
                            if (tgt_be[k]) shadow[k] = tgt_wdata[8*k +: 8];
                end else if (tgt_sel16) begin
                    tgt_rdata = {16'h5A5A, fb(wb + {tgt_addr[1], 1'b1}), fb(wb + {tgt_addr[1], 1'b0})};
                    if (tgt_write) begin
                        if (!tgt_addr[0]) shadow[{tgt_addr[1], 1'b0}] = tgt_wdata[7:0];
                        if (tgt_bhe)      shadow[{tgt_addr[1], 1'b1}] = tgt_wdata[15:8];
                    end
                end else begin
                    tgt_rdata = {24'hC3C3C3, fb(tgt_addr)};
                    if (tgt_write) shadow[tgt_addr[1:0]] = tgt_wdata[7:0];
                end
            end
        end else begin
            tgt_ready = 1'b0;
            wcnt = 0;
        end
    end

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", what, act, exp);
        end
    endtask

    // w: 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = both selects
    task automatic run_txn(input int w, input logic [3:0] be, input logic wr,
                           input logic [AW-1:0] addr, input logic [31:0] wd,
                           input int wt, input int exp_n, input logic [7:0] exp_low,
                           input logic [3:0] exp_bhe, input string tag, input bit hold);
        int start;
        int cyc;
        logic [7:0]  snap [4];
        logic [31:0] got_rd;
        logic [31:0] exp_rd;
        logic [AW-1:0] base;
        @(negedge clk);
        tgt_sel32 = (w >= 2);
        tgt_sel16 = (w == 1) || (w == 3);
        waitn = wt;
        @(negedge clk);
        start = total;
        for (int k = 0; k < 4; k++) snap[k] = shadow[k];
        cpu_req = 1'b1; cpu_be = be; cpu_write = wr; cpu_addr = addr; cpu_wdata = wd;
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!cpu_ready && cyc < 300);
        got_rd = cpu_rdata;
        if (hold) begin
            @(negedge clk);
            chk(!tgt_cyc && !cpu_ready, {tag, " R9 held request restarted"}, {30'd0, tgt_cyc, cpu_ready}, 32'd0);
        end
        cpu_req = 1'b0;
        chk(cyc == 1 + exp_n * (wt + 1), {tag, " R8 latency"}, 32'(cyc), 32'(1 + exp_n * (wt + 1)));
        chk(total - start == exp_n, {tag, " sub-cycle count"}, 32'(total - start), 32'(exp_n));
        for (int k = 0; k < exp_n && k < 4; k++) begin
            chk(log_low[(start + k) % 64] == exp_low[2*k +: 2], {tag, " R6 address low bits"},
                32'(log_low[(start + k) % 64]), 32'(exp_low[2*k +: 2]));
            chk(log_bhe[(start + k) % 64] == exp_bhe[k], {tag, " R4 byte-high enable"},
                32'(log_bhe[(start + k) % 64]), 32'(exp_bhe[k]));
        end
        base = {addr[AW-1:2], 2'b00};
        if (!wr) begin
            for (int k = 0; k < 4; k++)
                exp_rd[8*k +: 8] = be[k] ? fb(base + AW'(k)) : 8'h00;
            chk(got_rd == exp_rd, {tag, " R7 read assembly"}, got_rd, exp_rd);
        end else begin
            for (int k = 0; k < 4; k++) begin
                logic [7:0] e;
                e = be[k] ? wd[8*k +: 8] : snap[k];
                chk(shadow[k] == e, {tag, " write lane content"}, 32'(shadow[k]), 32'(e));
            end
        end
    endtask

    // {width, be, count, lows (sub0 in [1:0]), bhe (sub0 in bit 0)}
    localparam logic [20:0] VEC [12] = '{
        {2'd2, 4'hF, 3'd1, 8'h00, 4'h0},
        {2'd2, 4'h6, 3'd1, 8'h00, 4'h0},
        {2'd1, 4'hF, 3'd2, 8'h08, 4'h3},
        {2'd1, 4'h2, 3'd1, 8'h01, 4'h1},
        {2'd1, 4'h4, 3'd1, 8'h02, 4'h0},
        {2'd1, 4'h9, 3'd2, 8'h0C, 4'h2},
        {2'd1, 4'hE, 3'd2, 8'h09, 4'h3},
        {2'd0, 4'hF, 3'd4, 8'hE4, 4'h0},
        {2'd0, 4'hA, 3'd2, 8'h0D, 4'h0},
        {2'd0, 4'h7, 3'd3, 8'h24, 4'h0},
        {2'd0, 4'h8, 3'd1, 8'h03, 4'h0},
        {2'd2, 4'hC, 3'd1, 8'h00, 4'h0}
    };

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog expired act=%h exp=%h", 32'd0, 32'd1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; cpu_req = 1'b0; cpu_addr = '0; cpu_be = '0; cpu_write = 1'b0;
        cpu_wdata = '0; tgt_sel32 = 1'b0; tgt_sel16 = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk(!cpu_ready && !tgt_cyc && !tgt_bhe, "R1 control outputs after reset",
            {29'd0, cpu_ready, tgt_cyc, tgt_bhe}, 32'd0);
        chk(cpu_rdata == 32'd0, "R1 read word after reset", cpu_rdata, 32'd0);

        for (int p = 0; p < 2; p++) begin
            for (int i = 0; i < 12; i++) begin
                int w;
                string tag;
                w = int'(VEC[i][20:19]);
                tag = (w == 2) ? "R2" : (w == 1) ? "R3" : "R5";
                run_txn(w, VEC[i][18:15], p[0], {22'(32'h1A2B0 + i), 2'(i)},
                        32'hA1B2C3D4 ^ (32'(i) * 32'h01010101), i % 3,
                        int'(VEC[i][14:12]), VEC[i][11:4], VEC[i][3:0], tag, 1'b0);
            end
        end

        // R10 both selects: 32-bit path wins
        run_txn(3, 4'hF, 1'b0, 24'h00C0F0, 32'h0, 0, 1, 8'h00, 4'h0, "R10", 1'b0);
        run_txn(3, 4'h5, 1'b1, 24'h00C0F4, 32'h13579BDF, 1, 1, 8'h00, 4'h0, "R10", 1'b0);
        // R11 no byte enabled
        run_txn(1, 4'h0, 1'b0, 24'h001000, 32'h0, 2, 0, 8'h00, 4'h0, "R11", 1'b0);
        // R8 long wait states on a four-part access
        run_txn(0, 4'hF, 1'b0, 24'h002220, 32'h0, 5, 4, 8'hE4, 4'h0, "R8", 1'b0);
        // R9 request held through the ready pulse
        run_txn(0, 4'h3, 1'b0, 24'h003330, 32'h0, 2, 2, 8'h04, 4'h0, "R9", 1'b1);
        // R4 odd byte alone on a 16-bit port, written
        run_txn(1, 4'h8, 1'b1, 24'h004440, 32'h77000000, 0, 1, 8'h03, 4'h1, "R4", 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule